// File: doc/BRIEF.md
# Way-Predicting Two-Way Cache Lookup

This block is the lookup path of a small two-way set-associative cache. Every set carries one prediction bit that names the way the next access to that set is expected to hit. When a request is accepted, only the predicted way's tag, valid bit and data are read. A single tag comparison then decides the result, and the data path is already steered to that way before the comparison finishes. A correct guess answers one cycle after the request is accepted.

When the guessed way does not match, the block spends one more cycle comparing the other way of the same set. A match there is still a hit, but it is reported as slow and the set's prediction bit is retrained to that way. When neither way matches, a miss is reported after that second cycle and the prediction bit is left alone.

Lines are installed through a one-cycle fill port. Each fill writes the way named by a per-set least-recently-used bit and points the prediction at the way it just wrote. The response carries a flag that tells whether the answer needed the extra cycle.

Top module: `wpc_top`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1, and every lookup is a miss because no line is valid.
- R2: The low `IDX_W` bits of an address select the set and the remaining upper bits form the tag. A line installed in one set is never found by a lookup that goes to another set.
- R3: A lookup whose tag is in the predicted way responds in the cycle after acceptance with `rsp_valid`=1, `rsp_hit`=1, `rsp_slow`=0 and that line's data.
- R4: A lookup whose tag is only in the other way responds two cycles after acceptance with `rsp_hit`=1, `rsp_slow`=1 and that line's data.
- R5: A lookup that matches neither way responds two cycles after acceptance with `rsp_hit`=0, `rsp_slow`=1 and `rsp_data`=0.
- R6: After a slow hit, the set's prediction points at the way that hit, so repeating the same lookup gives a fast hit.
- R7: A miss leaves the set's prediction unchanged: a following lookup of the line in the previously predicted way is still fast.
- R8: A fill writes the set's least-recently-used way and makes that way the prediction, so a lookup of the filled address right afterwards is a fast hit.
- R9: Any hit marks its way as recently used, which makes the other way of the set the next fill victim. Two fills in a row to one set therefore keep both lines.
- R10: `req_ready` is 0 during the second lookup cycle and in any cycle where `fill_valid` is 1. It is 1 otherwise.
- R11: Each accepted request yields exactly one single-cycle response pulse, one or two cycles after acceptance. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Lookup address: tag above the set index |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| rsp_valid | output | 1 | Response present, one-cycle pulse |
| rsp_data | output | DATA_W | Line data on hit, zero on miss |
| rsp_hit | output | 1 | Lookup found its tag |
| rsp_slow | output | 1 | Result needed the second lookup cycle |
| fill_valid | input | 1 | Install a line this cycle |
| fill_addr | input | ADDR_W | Address of the installed line |
| fill_data | input | DATA_W | Data of the installed line |

## Verification
A fast hit is due at the first falling edge after the accepting rising edge, because the only register on its path is the response register. A slow hit or a miss adds the second-cycle register, so at that first falling edge the bench expects `rsp_valid` low and `req_ready` low, and it expects the response at the next falling edge. The bench keeps a reference copy of tags, prediction bits and LRU bits, updated from the requirements. For each request it works out in advance whether the response will be fast, slow or a miss, and samples exactly at the matching edge. After every response it also checks, one cycle later, that the pulse has ended.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic {
        LK_FIRST  = 1'b0,
        LK_SECOND = 1'b1
    } lk_state_e;

    typedef logic way_t;

    function automatic way_t other_way(input way_t w);
        return ~w;
    endfunction

endpackage

// File: rtl/wpc_store.sv
module wpc_store #(
    parameter int SETS   = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_way,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int WAYS = 2;

    logic              way_vld [WAYS];
    logic [TAG_W-1:0]  way_tag [WAYS];
    logic [DATA_W-1:0] way_dat [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]   vld_q;
        logic [TAG_W-1:0]  tag_q [SETS];
        logic [DATA_W-1:0] dat_q [SETS];

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
            end else if (wr_en && (wr_way == 1'(w))) begin
                vld_q[wr_idx] <= 1'b1;
                tag_q[wr_idx] <= wr_tag;
                dat_q[wr_idx] <= wr_data;
            end
        end

        assign way_vld[w] = vld_q[rd_idx];
        assign way_tag[w] = tag_q[rd_idx];
        assign way_dat[w] = dat_q[rd_idx];
    end

    // Single read port: the way is chosen before any tag comparison.
    assign rd_valid = way_vld[rd_way];
    assign rd_tag   = way_tag[rd_way];
    assign rd_data  = way_dat[rd_way];

endmodule

// File: rtl/wpc_policy.sv
module wpc_policy #(
    parameter int SETS  = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             pred_way,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             hit_way,
    input  logic             retrain,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    output logic             victim_way
);
    logic [SETS-1:0] pred_q;
    logic [SETS-1:0] lru_q;   // names the way to replace next

    assign pred_way   = pred_q[rd_idx];
    assign victim_way = lru_q[fill_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_q <= '0;
            lru_q  <= '0;
        end else begin
            if (hit_en) begin
                lru_q[hit_idx] <= ~hit_way;
                if (retrain) pred_q[hit_idx] <= hit_way;
            end
            // A fill on the same set takes precedence.
            if (fill_en) begin
                lru_q[fill_idx]  <= ~victim_way;
                pred_q[fill_idx] <= victim_way;
            end
        end
    end

endmodule

// File: rtl/wpc_top.sv
module wpc_top
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_hit,
    output logic              rsp_slow,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int SETS  = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    lk_state_e         state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    way_t              way_q;

    logic [IDX_W-1:0]  req_idx, look_idx;
    logic [TAG_W-1:0]  req_tag, look_tag, rd_tag;
    way_t              pred_way, look_way, victim_way;
    logic              rd_valid, match, accept, second;
    logic [DATA_W-1:0] rd_data;

    logic              rsp_valid_q, rsp_hit_q, rsp_slow_q;
    logic [DATA_W-1:0] rsp_data_q;

    assign req_idx   = req_addr[IDX_W-1:0];
    assign req_tag   = req_addr[ADDR_W-1:IDX_W];
    assign second    = (state_q == LK_SECOND);
    assign req_ready = !second && !fill_valid;
    assign accept    = req_valid && req_ready;

    assign look_idx  = second ? idx_q : req_idx;
    assign look_tag  = second ? tag_q : req_tag;
    assign look_way  = second ? way_q : pred_way;
    assign match     = rd_valid && (rd_tag == look_tag);

    wpc_store #(
        .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (look_idx),
        .rd_way   (look_way),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .wr_en    (fill_valid),
        .wr_way   (victim_way),
        .wr_idx   (fill_addr[IDX_W-1:0]),
        .wr_tag   (fill_addr[ADDR_W-1:IDX_W]),
        .wr_data  (fill_data)
    );

    wpc_policy #(
        .SETS(SETS), .IDX_W(IDX_W)
    ) u_policy (
        .clk        (clk),
        .rst        (rst),
        .rd_idx     (req_idx),
        .pred_way   (pred_way),
        .hit_en     (match && (accept || second)),
        .hit_idx    (look_idx),
        .hit_way    (look_way),
        .retrain    (second),
        .fill_en    (fill_valid),
        .fill_idx   (fill_addr[IDX_W-1:0]),
        .victim_way (victim_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= LK_FIRST;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_slow_q  <= 1'b0;
            rsp_data_q  <= '0;
            idx_q       <= '0;
            tag_q       <= '0;
            way_q       <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (second) begin
                rsp_valid_q <= 1'b1;
                rsp_hit_q   <= match;
                rsp_slow_q  <= 1'b1;
                rsp_data_q  <= match ? rd_data : '0;
                state_q     <= LK_FIRST;
            end else if (accept) begin
                if (match) begin
                    rsp_valid_q <= 1'b1;
                    rsp_hit_q   <= 1'b1;
                    rsp_slow_q  <= 1'b0;
                    rsp_data_q  <= rd_data;
                end else begin
                    state_q <= LK_SECOND;
                    idx_q   <= req_idx;
                    tag_q   <= req_tag;
                    way_q   <= other_way(pred_way);
                end
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_slow  = rsp_slow_q;
    assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_slow,
    input logic [DATA_W-1:0] rsp_data,
    input logic              fill_valid
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid);

    p_fast_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_slow) |-> $past(req_valid && req_ready));

    p_slow_after_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_slow) |-> !$past(req_ready));

    p_miss_clears_data_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_slow && rsp_data == '0));

    p_ready_low_wait_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid && req_ready) && !rsp_valid) |-> !req_ready);

    p_ready_low_fill_r10: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> !req_ready);

    p_resp_has_request_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && req_ready, 1) || $past(req_valid && req_ready, 2)));

endmodule

bind wpc_top wpc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_slow   (rsp_slow),
    .rsp_data   (rsp_data),
    .fill_valid (fill_valid)
);

// File: tb/tb_wpc_top.sv
module tb_wpc_top;
    localparam int AW   = 6;
    localparam int IW   = 2;
    localparam int DW   = 16;
    localparam int SETS = 1 << IW;
    localparam int TW   = AW - IW;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_ready, rsp_valid, rsp_hit, rsp_slow, fill_valid;
    logic [AW-1:0] req_addr, fill_addr;
    logic [DW-1:0] rsp_data, fill_data;

    int errs   = 0;
    int checks = 0;

    bit          m_vld [2][SETS];
    bit [TW-1:0] m_tag [2][SETS];
    bit [DW-1:0] m_dat [2][SETS];
    bit          m_pred [SETS];
    bit          m_lru  [SETS];

    always #5 clk = ~clk;

    wpc_top #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit), .rsp_slow(rsp_slow),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return (DW'(a) * 16'h0101) ^ 16'h5a3c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fill(input logic [AW-1:0] a);
        bit v;
        int s;
        s = int'(a[IW-1:0]);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = a;
        fill_data  = pat(a);
        #1 chk("R10 ready during fill", 32'(req_ready), 0);
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
        v = m_lru[s];
        m_vld[v][s] = 1'b1;
        m_tag[v][s] = a[AW-1:IW];
        m_dat[v][s] = pat(a);
        m_lru[s]    = ~v;
        m_pred[s]   = v;
    endtask

    // kind: 0 fast hit, 1 slow hit, 2 miss
    task automatic do_req(input logic [AW-1:0] a, output int kind);
        int s;
        bit pw, ow, fast, slowhit;
        s       = int'(a[IW-1:0]);
        pw      = m_pred[s];
        ow      = ~pw;
        fast    = m_vld[pw][s] && (m_tag[pw][s] == a[AW-1:IW]);
        slowhit = !fast && m_vld[ow][s] && (m_tag[ow][s] == a[AW-1:IW]);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        #1 chk("R10 ready when idle", 32'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (fast) begin
            kind = 0;
            chk("R3 valid", 32'(rsp_valid), 1);
            chk("R3 hit",   32'(rsp_hit), 1);
            chk("R3 slow",  32'(rsp_slow), 0);
            chk("R3 data",  32'(rsp_data), 32'(m_dat[pw][s]));
            m_lru[s] = ow;
        end else begin
            kind = slowhit ? 1 : 2;
            chk("R10 ready in second cycle", 32'(req_ready), 0);
            chk("R4 no early response", 32'(rsp_valid), 0);
            @(negedge clk);
            chk(slowhit ? "R4 valid" : "R5 valid", 32'(rsp_valid), 1);
            chk(slowhit ? "R4 hit"   : "R5 hit",   32'(rsp_hit), 32'(slowhit));
            chk(slowhit ? "R4 slow"  : "R5 slow",  32'(rsp_slow), 1);
            chk(slowhit ? "R4 data"  : "R5 data",  32'(rsp_data),
                slowhit ? 32'(m_dat[ow][s]) : 0);
            if (slowhit) begin
                m_pred[s] = ow;
                m_lru[s]  = pw;
            end
        end
        @(negedge clk);
        chk("R11 single pulse", 32'(rsp_valid), 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int k;
        logic [AW-1:0] A, B, C, D, E;
        A = {4'd1, 2'd1};
        B = {4'd2, 2'd1};
        C = {4'd3, 2'd1};
        D = {4'd4, 2'd1};
        E = {4'd1, 2'd2};
        rst = 1'b1; req_valid = 1'b0; fill_valid = 1'b0;
        req_addr = '0; fill_addr = '0; fill_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);
        chk("R1 ready after reset",     32'(req_ready), 1);
        do_req(6'h05, k); chk("R1 empty cache misses", 32'(k), 2);

        do_fill(A);
        do_req(A, k); chk("R8 filled line fast", 32'(k), 0);
        do_fill(B);
        do_req(B, k); chk("R8 second fill fast", 32'(k), 0);
        do_req(A, k); chk("R9 both lines kept, slow hit", 32'(k), 1);
        do_req(A, k); chk("R6 retrained fast", 32'(k), 0);
        do_req(C, k); chk("R5 absent tag misses", 32'(k), 2);
        do_req(A, k); chk("R7 miss kept prediction", 32'(k), 0);
        do_req(B, k); chk("R4 other way slow hit", 32'(k), 1);
        do_fill(D);
        do_req(A, k); chk("R9 LRU victim evicted", 32'(k), 2);
        do_req(B, k); chk("R9 recent line kept", 32'(k), 1);
        do_fill(E);
        do_req(E, k); chk("R2 other set fast", 32'(k), 0);
        do_req({4'd1, 2'd3}, k); chk("R2 same tag other set misses", 32'(k), 2);

        for (int i = 0; i < 240; i++) begin
            if (i % 3 == 0) do_fill(AW'((i * 29 + 5) % 64));
            do_req(AW'((i * 13 + i / 7) % 64), k);
        end
        finish_run();
    end

endmodule